// File: doc/BRIEF.md
# Synchronous serial character engine

The engine is the character-level transmit and receive path of a serial port that runs from a clock line. The clock line is either driven by a partner device or generated elsewhere on the chip. The transmitter takes a parallel word and sends it on a data output as a framed character. The frame is a low start bit, then the data bits least significant first, then one high stop bit. The receiver watches a data input, finds a low start bit and shifts in the configured number of data bits. It then presents the word on a parallel read port.

Both directions follow the serial clock. The clock line and the received data line are synchronised into the system clock domain, and edges of the clock line are detected there. A polarity input chooses which clock edge launches outgoing bits. The opposite edge then samples incoming bits. A 3-bit size code chooses five to nine data bits. For nine-bit words, the top bit travels on its own input and output. A mode input says whether the port is in synchronous operation. Outside that mode the polarity input has no effect.

Top module: `sync_char_engine`

## Requirements
- R1: Size codes 3'b000, 3'b001, 3'b010 and 3'b011 give characters of 5, 6, 7 and 8 data bits. The received word holds exactly those bits, with every higher bit of `rxData` read as zero.
- R2: Size code 3'b111 gives a 9-bit character. Bit 8 is sent from `txBit8` after the eight bits of `txData` and is returned on `rxBit8`.
- R3: Size codes 3'b100, 3'b101 and 3'b110 drive `sizeErr` high. While such a code is present, `txLoad` is ignored: `txBusy` stays 0 and `txOut` stays 1. A low level on `rxIn` starts no reception either, so no `rxDone` pulse appears.
- R4: With `syncMode`=1 and `clkPol`=0, `txOut` changes only after a rising edge of `xck`, and `rxIn` is sampled on the falling edge.
- R5: With `syncMode`=1 and `clkPol`=1, `txOut` changes only after a falling edge of `xck`, and `rxIn` is sampled on the rising edge.
- R6: With `syncMode`=0, `clkPol` is ignored and the engine uses the edges of R4.
- R7: `txOut` idles at 1. A character is a 0 start bit, then the data bits LSB first, then a 1 stop bit, each launched on its own launch edge. `txBusy` rises the cycle after an accepted `txLoad` and falls when the stop bit is launched. A `txLoad` while `txBusy` is high is ignored.
- R8: Size and polarity are captured when a character starts (a load, or a detected start bit). Changing them mid-character does not alter that character.
- R9: `rxDone` pulses high for exactly one system clock per received character, after the last configured data bit is sampled. `rxData`/`rxBit8` hold the word from that cycle on.
- R10: After reset, `txOut` is 1 and `txBusy`, `rxDone`, `rxData` and `rxBit8` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncMode | input | 1 | 1 = synchronous operation; 0 = polarity ignored |
| clkPol | input | 1 | Edge selection: 0 launches on rising, 1 launches on falling |
| sizeCode | input | 3 | Character size code |
| txLoad | input | 1 | One-cycle request to send `{txBit8, txData}` |
| txData | input | 8 | Low eight data bits to send |
| txBit8 | input | 1 | Ninth data bit to send |
| txBusy | output | 1 | A character is in flight on `txOut` |
| sizeErr | output | 1 | Current size code is reserved |
| xck | input | 1 | Serial clock line |
| txOut | output | 1 | Serial data output |
| rxIn | input | 1 | Serial data input |
| rxData | output | 8 | Low eight bits of the last received word |
| rxBit8 | output | 1 | Ninth bit of the last received word |
| rxDone | output | 1 | One-cycle pulse when a word has been received |

## Verification
On every cycle, the embedded assertions check several properties. The output line sits high whenever no character is in flight. A transfer never begins under a reserved size code. The latched character length stays within five to nine and holds steady for the whole character. The completion strobe never lasts two cycles. Only the bench's scenarios can show other properties. One is that each edge choice launches and samples on the intended clock edge. Others are that the mode input overrides polarity, that loopback words come back intact and correctly truncated, and that mid-character changes to the configuration or a second load have no effect.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int MAX_BITS = 9;
  localparam int CNT_W = $clog2(MAX_BITS + 2);

  typedef struct packed {
    logic txLoad;
    logic txStartBit;
    logic txShift;
    logic txStopBit;
    logic rxShift;
    logic rxFinish;
  } strobeT;

  // returns 0 for a reserved code
  function automatic logic [CNT_W-1:0] decodeSize(input logic [2:0] code);
    case (code)
      3'b000:  return CNT_W'(5);
      3'b001:  return CNT_W'(6);
      3'b010:  return CNT_W'(7);
      3'b011:  return CNT_W'(8);
      3'b111:  return CNT_W'(9);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sce_ctrl.sv
module sce_ctrl
  import sce_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncMode,
  input  logic             clkPol,
  input  logic [2:0]       sizeCode,
  input  logic             txLoadReq,
  input  logic             xck,
  input  logic             rxLevel,
  output strobeT           strobe,
  output logic             txBusy,
  output logic             sizeErr,
  output logic [CNT_W-1:0] rxBits
);
  logic [SYNC_STAGES-1:0] xckPipe;
  logic xckPrev, xckNow, riseEdge, fallEdge, effPol;
  logic [CNT_W-1:0] sizeNow;
  logic sizeReserved;

  logic txBusyQ, txPolQ, txLaunch;
  logic [CNT_W-1:0] txCnt, txBitsQ;
  logic rxBusyQ, rxPolQ, rxSampleIdle, rxSampleBusy, rxStart;
  logic [CNT_W-1:0] rxCnt, rxBitsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xckPipe <= '0;
      xckPrev <= 1'b0;
    end else begin
      xckPipe <= {xckPipe[SYNC_STAGES-2:0], xck};
      xckPrev <= xckPipe[SYNC_STAGES-1];
    end
  end

  assign xckNow   = xckPipe[SYNC_STAGES-1];
  assign riseEdge = xckNow & ~xckPrev;
  assign fallEdge = ~xckNow & xckPrev;
  assign effPol   = clkPol & syncMode;
  assign sizeNow  = decodeSize(sizeCode);
  assign sizeReserved = (sizeNow == '0);
  assign sizeErr  = sizeReserved;

  // transmit sequencing
  assign txLaunch = txPolQ ? fallEdge : riseEdge;

  always_comb begin
    strobe = '0;
    strobe.txLoad     = txLoadReq & ~txBusyQ & ~sizeReserved;
    strobe.txStartBit = txBusyQ & txLaunch & (txCnt == '0);
    strobe.txShift    = txBusyQ & txLaunch & (txCnt != '0) & (txCnt <= txBitsQ);
    strobe.txStopBit  = txBusyQ & txLaunch & (txCnt == txBitsQ + CNT_W'(1));
    strobe.rxShift    = rxBusyQ & rxSampleBusy;
    strobe.rxFinish   = rxBusyQ & rxSampleBusy & (rxCnt == rxBitsQ - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusyQ <= 1'b0;
      txPolQ  <= 1'b0;
      txCnt   <= '0;
      txBitsQ <= CNT_W'(5);
    end else if (strobe.txLoad) begin
      txBusyQ <= 1'b1;
      txPolQ  <= effPol;
      txCnt   <= '0;
      txBitsQ <= sizeNow;
    end else if (txBusyQ && txLaunch) begin
      if (strobe.txStopBit) txBusyQ <= 1'b0;
      else                  txCnt   <= txCnt + CNT_W'(1);
    end
  end

  // receive sequencing: sample on the edge opposite to launch
  assign rxSampleIdle = effPol ? riseEdge : fallEdge;
  assign rxSampleBusy = rxPolQ ? riseEdge : fallEdge;
  assign rxStart      = ~rxBusyQ & rxSampleIdle & ~rxLevel & ~sizeReserved;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBusyQ <= 1'b0;
      rxPolQ  <= 1'b0;
      rxCnt   <= '0;
      rxBitsQ <= CNT_W'(5);
    end else if (rxStart) begin
      rxBusyQ <= 1'b1;
      rxPolQ  <= effPol;
      rxCnt   <= '0;
      rxBitsQ <= sizeNow;
    end else if (strobe.rxShift) begin
      if (strobe.rxFinish) rxBusyQ <= 1'b0;
      else                 rxCnt   <= rxCnt + CNT_W'(1);
    end
  end

  assign txBusy = txBusyQ;
  assign rxBits = rxBitsQ;

  // R3
  tx_no_reserved_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusyQ) |-> !$past(sizeReserved));
  // R1
  tx_len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBusyQ |-> (txBitsQ >= CNT_W'(5) && txBitsQ <= CNT_W'(MAX_BITS)));
  // R8
  tx_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBusyQ && $past(txBusyQ)) |-> ($stable(txBitsQ) && $stable(txPolQ)));
  // R8
  rx_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxBusyQ && $past(rxBusyQ)) |-> ($stable(rxBitsQ) && $stable(rxPolQ)));
endmodule

// File: rtl/sce_datapath.sv
module sce_datapath
  import sce_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  logic [MAX_BITS-1:0] txWord,
  input  logic [CNT_W-1:0]    rxBits,
  input  logic                rxIn,
  output logic                txOut,
  output logic                rxLevel,
  output logic [MAX_BITS-1:0] rxWord,
  output logic                rxDone
);
  localparam logic [CNT_W-1:0] FULL_BITS = CNT_W'(MAX_BITS);

  logic [MAX_BITS-1:0] txSr, rxSr, rxNext;
  logic [SYNC_STAGES-1:0] rxPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSr  <= '0;
      txOut <= 1'b1;
    end else begin
      if (strobe.txLoad)       txSr <= txWord;
      else if (strobe.txShift) txSr <= txSr >> 1;
      if (strobe.txStartBit)     txOut <= 1'b0;
      else if (strobe.txShift)   txOut <= txSr[0];
      else if (strobe.txStopBit) txOut <= 1'b1;
    end
  end

  assign rxLevel = rxPipe[SYNC_STAGES-1];
  assign rxNext  = {rxLevel, rxSr[MAX_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPipe <= '1;
      rxSr   <= '0;
      rxWord <= '0;
      rxDone <= 1'b0;
    end else begin
      rxPipe <= {rxPipe[SYNC_STAGES-2:0], rxIn};
      rxDone <= strobe.rxFinish;
      if (strobe.rxShift)  rxSr   <= rxNext;
      if (strobe.rxFinish) rxWord <= rxNext >> (FULL_BITS - rxBits);
    end
  end

  // R9
  rx_done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);
endmodule

// File: rtl/sync_char_engine.sv
module sync_char_engine
  import sce_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncMode,
  input  logic       clkPol,
  input  logic [2:0] sizeCode,
  input  logic       txLoad,
  input  logic [7:0] txData,
  input  logic       txBit8,
  output logic       txBusy,
  output logic       sizeErr,
  input  logic       xck,
  output logic       txOut,
  input  logic       rxIn,
  output logic [7:0] rxData,
  output logic       rxBit8,
  output logic       rxDone
);
  strobeT strobe;
  logic rxLevel;
  logic [CNT_W-1:0] rxBits;
  logic [MAX_BITS-1:0] rxWord;

  sce_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .clkPol(clkPol),
    .sizeCode(sizeCode), .txLoadReq(txLoad), .xck(xck), .rxLevel(rxLevel),
    .strobe(strobe), .txBusy(txBusy), .sizeErr(sizeErr), .rxBits(rxBits)
  );

  sce_datapath #(.SYNC_STAGES(SYNC_STAGES)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWord({txBit8, txData}),
    .rxBits(rxBits), .rxIn(rxIn), .txOut(txOut), .rxLevel(rxLevel),
    .rxWord(rxWord), .rxDone(rxDone)
  );

  assign rxData = rxWord[7:0];
  assign rxBit8 = rxWord[8];

  // R7
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txOut);
endmodule

// File: tb/sync_char_engine_test.sv
module sync_char_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NVEC = 8;
  // {pol, sizeCode, sent word, expected received word}
  localparam logic [21:0] VECS [NVEC] = '{
    {1'b0, 3'b000, 9'h0F3, 9'h013},
    {1'b1, 3'b001, 9'h0AA, 9'h02A},
    {1'b0, 3'b010, 9'h1FF, 9'h07F},
    {1'b1, 3'b011, 9'h15A, 9'h05A},
    {1'b0, 3'b111, 9'h1A5, 9'h1A5},
    {1'b1, 3'b111, 9'h0C3, 9'h0C3},
    {1'b0, 3'b011, 9'h001, 9'h001},
    {1'b1, 3'b000, 9'h1E0, 9'h000}
  };

  logic clk = 0, rstN = 0, syncMode = 1, clkPol = 0, txLoad = 0, txBit8 = 0;
  logic [2:0] sizeCode = 3'b011;
  logic [7:0] txData = 0;
  logic xck = 0, loopOn = 1, rxDrive = 1;
  logic txBusy, sizeErr, txOut, rxBit8, rxDone, rxIn;
  logic [7:0] rxData;
  int nChecks = 0, nFail = 0, doneCount = 0, lowSeen = 0;
  logic [8:0] gotWord = 0;
  bit finished = 0;

  assign rxIn = loopOn ? txOut : rxDrive;

  sync_char_engine uut (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .clkPol(clkPol),
    .sizeCode(sizeCode), .txLoad(txLoad), .txData(txData), .txBit8(txBit8),
    .txBusy(txBusy), .sizeErr(sizeErr), .xck(xck), .txOut(txOut),
    .rxIn(rxIn), .rxData(rxData), .rxBit8(rxBit8), .rxDone(rxDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rxDone) begin
      doneCount++;
      gotWord = {rxBit8, rxData};
    end
    if (!txOut) lowSeen++;
  endtask

  task automatic halfPeriod();
    xck = ~xck;
    repeat (HALF) tick();
  endtask

  task automatic loadWord(input logic [8:0] w);
    txData = w[7:0];
    txBit8 = w[8];
    txLoad = 1;
    tick();
    txLoad = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    if (!finished) begin
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check(txOut == 1 && txBusy == 0 && rxDone == 0, "R10 outputs in reset", {txOut, txBusy, rxDone}, 3'b100);
    rstN = 1;
    tick();
    check(rxData == 0 && rxBit8 == 0, "R10 rx word after reset", {rxBit8, rxData}, 0);

    // loopback vector table: R1 R2 R4 R5 R9
    for (int i = 0; i < NVEC; i++) begin
      clkPol = VECS[i][21];
      sizeCode = VECS[i][20:18];
      doneCount = 0;
      loadWord(VECS[i][17:9]);
      check(txBusy == 1, "R7 busy after load", txBusy, 1);
      repeat (24) halfPeriod();
      check(doneCount == 1, "R9 single done pulse", doneCount, 1);
      check(gotWord == VECS[i][8:0], VECS[i][20:18] == 3'b111 ? "R2 nine-bit word" : "R1 sized word",
            gotWord, VECS[i][8:0]);
      check(txBusy == 0 && txOut == 1, "R7 idle after stop", {txBusy, txOut}, 2'b01);
    end

    // R3 reserved codes
    for (int c = 4; c < 7; c++) begin
      sizeCode = 3'(c);
      tick();
      check(sizeErr == 1, "R3 reserved flag", sizeErr, 1);
    end
    loopOn = 0; rxDrive = 0; doneCount = 0; lowSeen = 0;
    loadWord(9'h000);
    repeat (16) halfPeriod();
    check(txBusy == 0 && lowSeen == 0, "R3 load ignored", lowSeen, 0);
    check(doneCount == 0, "R3 no reception", doneCount, 0);
    rxDrive = 1;
    repeat (4) halfPeriod();
    sizeCode = 3'b011;
    tick();
    check(sizeErr == 0, "R3 valid code clears flag", sizeErr, 0);
    loopOn = 1;

    // R4 launch edge with polarity 0
    clkPol = 0;
    loadWord(9'h0FF);
    repeat (4) tick();
    check(txOut == 1, "R4 no change before edge", txOut, 1);
    halfPeriod();
    check(txOut == 0, "R4 start after rising", txOut, 0);
    halfPeriod();
    check(txOut == 0, "R4 no change on falling", txOut, 0);
    halfPeriod();
    check(txOut == 1, "R4 data after rising", txOut, 1);
    repeat (23) halfPeriod();

    // R5 launch edge with polarity 1
    clkPol = 1;
    loadWord(9'h0FF);
    halfPeriod();
    check(txOut == 1, "R5 no change on rising", txOut, 1);
    halfPeriod();
    check(txOut == 0, "R5 start after falling", txOut, 0);
    repeat (24) halfPeriod();

    // R6 asynchronous mode ignores polarity
    syncMode = 0; clkPol = 1;
    loadWord(9'h0FF);
    halfPeriod();
    check(txOut == 0, "R6 rising launch in async", txOut, 0);
    repeat (25) halfPeriod();
    syncMode = 1; clkPol = 0;

    // R8 mid-character configuration change, plus R7 load while busy
    sizeCode = 3'b011; doneCount = 0;
    loadWord(9'h0FF);
    repeat (4) halfPeriod();
    sizeCode = 3'b000; clkPol = 1;
    loadWord(9'h000);
    repeat (20) halfPeriod();
    check(doneCount == 1, "R8 one character", doneCount, 1);
    check(gotWord == 9'h0FF, "R8 config held, R7 busy load ignored", gotWord, 9'h0FF);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule